// File: doc/BRIEF.md
# Slow-Clock Watchdog Timer

This block is a watchdog timer. Its down-counter runs on a 32768 Hz slow clock, and its registers sit on a plain synchronous read/write bus in the system clock domain. Software programs a timeout and a reset-enable flag, then arms or refreshes the timer by writing a restart command. If no restart arrives before the timeout runs out, the block raises a sticky overflow flag that doubles as an interrupt request. When reset-enable was set at the last restart, it also drives a fixed-length reset pulse toward the chip's reset controller.

The timeout is counted in coarse units of 64 slow-clock periods, so a value of 2 expires after 128 slow clocks, about 4 ms. Changing the mode word does not restart the count. The new value is picked up only when the next restart command arrives. A mode word of all zeros stops the watchdog outright.

Both clock domains sit inside the block. A restart command crosses to the slow domain as a toggle, together with a snapshot of the mode word taken when the command was written. The overflow event crosses back to the bus domain as a toggle.

Top module: `slowclk_wdt`

## Requirements
- R1: After reset, the mode register reads 0, the watchdog is stopped, and `wd_rst` and `irq` are low.
- R2: Address 0 is the mode register. Bits 15:0 hold the timeout in units of 64 slow clocks, bit 16 holds reset-enable, and all other bits read 0. Address 1 is the control register and reads 0. Read data appears on `rdata` in the system cycle after the `rd_en` cycle.
- R3: Writing address 1 with bit 0 set restarts the watchdog from the mode value held at the time of the write. With timeout T, `wd_rst` rises after the (64·T+3)-th slow-clock rising edge that follows the write. This count includes two synchroniser stages and one edge-detect stage.
- R4: Each restart also clears the 64-cycle prescaler. A restart issued mid-count therefore gives a full timeout measured from that restart, and no pulse is produced in between.
- R5: Writing the mode register does not restart the counter. A running count keeps its old timeout, and the new value takes effect at the next restart.
- R6: On expiry with reset-enable set, `wd_rst` is high for exactly 4 consecutive slow-clock cycles.
- R7: On expiry with reset-enable clear, `wd_rst` stays low but the overflow status is still set.
- R8: The overflow status is bit 0 of address 2 and drives `irq`. It stays set until address 2 is read. That read returns the value before clearing, and `irq` is low afterwards.
- R9: A mode word of all zeros disables the watchdog. A running count stops within 3 slow cycles, and later restarts are ignored, so neither expiry nor `irq` occurs.
- R10: A restart loaded with timeout field 0 and a nonzero mode word leaves the counter idle, with no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | 32768 Hz count clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select (0 mode, 1 control, 2 status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wd_rst | output | 1 | Watchdog reset pulse, slow domain |
| irq | output | 1 | Sticky overflow status / interrupt |

## Verification
Expiry is due on slow-clock edge 64·T+3 after the restart write, and the reset pulse lasts 4 slow cycles. The bench issues each restart a few nanoseconds after a slow rising edge, so the first synchroniser stage samples on the next edge with a known count. It then counts slow edges and samples `wd_rst` on falling edges, which makes the edge number exact rather than windowed. Status readback is due one system cycle after the read strobe and is sampled on the following falling edge. `irq` is checked several system cycles after the pulse begins, which leaves room for the three-stage return crossing. Ignore cases (mode writes, disable, zero timeout) are checked by watching the outputs over spans of several hundred slow cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    parameter int unsigned WDT_TMO_W  = 16;
    parameter int unsigned WDT_DATA_W = 32;
    parameter int unsigned WDT_ADDR_W = 2;

    localparam int unsigned EN_BIT      = WDT_TMO_W;
    localparam int unsigned RESTART_BIT = 0;
    localparam int unsigned OVF_BIT     = 0;

    typedef enum logic [WDT_ADDR_W-1:0] {
        SEL_MODE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic                 arm_rst;
        logic [WDT_TMO_W-1:0] tmo;
    } mode_t;

    function automatic mode_t word_to_mode(input logic [WDT_DATA_W-1:0] w);
        mode_t m;
        m.arm_rst = w[EN_BIT];
        m.tmo     = w[WDT_TMO_W-1:0];
        return m;
    endfunction

    function automatic logic [WDT_DATA_W-1:0] mode_to_word(input mode_t m);
        logic [WDT_DATA_W-1:0] w;
        w                  = '0;
        w[EN_BIT]          = m.arm_rst;
        w[WDT_TMO_W-1:0]   = m.tmo;
        return w;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W      = WDT_DATA_W,
    parameter int unsigned ADDR_W      = WDT_ADDR_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf_tgl_a,
    output mode_t             snap_o,
    output logic              restart_tgl_o,
    output logic              disable_o,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    mode_t             mode_q;
    mode_t             snap_q;
    logic              rs_tgl_q;
    logic              dis_q;
    logic              ovf_s;
    logic              ovf_last_q;
    logic              ovf_p;
    logic              stat_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_mode, wr_ctrl, rd_stat;

    wdt_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ovf_sync (
        .clk (clk),
        .rst (rst),
        .d   (ovf_tgl_a),
        .q   (ovf_s)
    );

    assign ovf_p   = ovf_s ^ ovf_last_q;
    assign wr_mode = wr_en && (addr == SEL_MODE);
    assign wr_ctrl = wr_en && (addr == SEL_CTRL) && wdata[RESTART_BIT];
    assign rd_stat = rd_en && (addr == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= '0;
            snap_q     <= '0;
            rs_tgl_q   <= 1'b0;
            dis_q      <= 1'b1;
            ovf_last_q <= 1'b0;
            stat_q     <= 1'b0;
        end else begin
            ovf_last_q <= ovf_s;
            dis_q      <= (mode_q == '0);
            if (wr_mode) mode_q <= word_to_mode(wdata);
            if (wr_ctrl) begin
                snap_q   <= mode_q;
                rs_tgl_q <= ~rs_tgl_q;
            end
            if (ovf_p)        stat_q <= 1'b1;
            else if (rd_stat) stat_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            case (addr)
                SEL_MODE: rdata_q <= mode_to_word(mode_q);
                SEL_STAT: begin
                    rdata_q          <= '0;
                    rdata_q[OVF_BIT] <= stat_q;
                end
                default:  rdata_q <= '0;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:WDT_TMO_W+1];

    assign snap_o        = snap_q;
    assign restart_tgl_o = rs_tgl_q;
    assign disable_o     = dis_q;
    assign rdata         = rdata_q;
    assign irq           = stat_q;
endmodule

// File: rtl/wdt_slow_core.sv
module wdt_slow_core
    import wdt_pkg::*;
#(
    parameter int unsigned TMO_W       = WDT_TMO_W,
    parameter int unsigned PRE_W       = 6,
    parameter int unsigned RST_LEN     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic  slow_clk,
    input  logic  slow_rst,
    input  logic  restart_tgl_a,
    input  logic  disable_a,
    input  mode_t snap_i,
    output logic  wd_rst,
    output logic  ovf_tgl_o
);
    localparam int unsigned RL_W = $clog2(RST_LEN + 1);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;
    localparam logic [RL_W-1:0]  RL_INIT = RL_W'(RST_LEN);

    logic             rs_s, rs_last_q, restart_p;
    logic             dis_s;
    logic             run_q;
    logic             arm_q;
    logic [TMO_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic [RL_W-1:0]  rl_q;
    logic             ovf_q;

    wdt_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rs_sync (
        .clk (slow_clk),
        .rst (slow_rst),
        .d   (restart_tgl_a),
        .q   (rs_s)
    );

    wdt_sync #(.STAGES(SYNC_STAGES), .W(1)) u_dis_sync (
        .clk (slow_clk),
        .rst (slow_rst),
        .d   (disable_a),
        .q   (dis_s)
    );

    assign restart_p = rs_s ^ rs_last_q;

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            rs_last_q <= 1'b0;
            run_q     <= 1'b0;
            arm_q     <= 1'b0;
            cnt_q     <= '0;
            pre_q     <= '0;
            rl_q      <= '0;
            ovf_q     <= 1'b0;
        end else begin
            rs_last_q <= rs_s;
            if (rl_q != '0) rl_q <= rl_q - 1'b1;
            if (dis_s) begin
                run_q <= 1'b0;
            end else if (restart_p) begin
                cnt_q <= snap_i.tmo;
                arm_q <= snap_i.arm_rst;
                pre_q <= '0;
                run_q <= (snap_i.tmo != '0);
            end else if (run_q) begin
                pre_q <= pre_q + 1'b1;
                if (pre_q == PRE_MAX) begin
                    if (cnt_q == TMO_W'(1)) begin
                        run_q <= 1'b0;
                        cnt_q <= '0;
                        ovf_q <= ~ovf_q;
                        if (arm_q) rl_q <= RL_INIT;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

    assign wd_rst    = (rl_q != '0);
    assign ovf_tgl_o = ovf_q;
endmodule

// File: rtl/slowclk_wdt.sv
module slowclk_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W      = WDT_DATA_W,
    parameter int unsigned ADDR_W      = WDT_ADDR_W,
    parameter int unsigned PRE_W       = 6,
    parameter int unsigned RST_LEN     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              slow_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wd_rst,
    output logic              irq
);
    mode_t snap;
    logic  restart_tgl;
    logic  disable_lvl;
    logic  ovf_tgl;

    wdt_bus_regs #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .ovf_tgl_a     (ovf_tgl),
        .snap_o        (snap),
        .restart_tgl_o (restart_tgl),
        .disable_o     (disable_lvl),
        .rdata         (rdata),
        .irq           (irq)
    );

    wdt_slow_core #(
        .TMO_W       (WDT_TMO_W),
        .PRE_W       (PRE_W),
        .RST_LEN     (RST_LEN),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_core (
        .slow_clk      (slow_clk),
        .slow_rst      (slow_rst),
        .restart_tgl_a (restart_tgl),
        .disable_a     (disable_lvl),
        .snap_i        (snap),
        .wd_rst        (wd_rst),
        .ovf_tgl_o     (ovf_tgl)
    );
endmodule

// File: rtl/slowclk_wdt_chk.sv
module slowclk_wdt_chk
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W  = WDT_DATA_W,
    parameter int unsigned ADDR_W  = WDT_ADDR_W,
    parameter int unsigned RST_LEN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              slow_clk,
    input logic              slow_rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              wd_rst,
    input logic              irq
);
    logic [7:0] hi_cnt;

    always_ff @(posedge slow_clk) begin
        if (slow_rst)    hi_cnt <= '0;
        else if (wd_rst) hi_cnt <= hi_cnt + 1'b1;
        else             hi_cnt <= '0;
    end

    // R1: bus side is quiet on the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && rdata == '0));

    // R1: slow side drives no pulse after reset
    p_slow_reset_r1: assert property (@(posedge slow_clk)
        slow_rst |=> !wd_rst);

    // R2: control register reads zero
    p_ctrl_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == SEL_CTRL) |=> rdata == '0);

    // R6: pulse never exceeds its length
    p_pulse_max_r6: assert property (@(posedge slow_clk) disable iff (slow_rst)
        wd_rst |-> hi_cnt < 8'(RST_LEN));

    // R6: pulse ends only after its full length
    p_pulse_len_r6: assert property (@(posedge slow_clk) disable iff (slow_rst)
        $fell(wd_rst) |-> hi_cnt == 8'(RST_LEN));

    // R8: status stays set until a status read
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !(rd_en && addr == SEL_STAT)) |=> irq);

    // R8: status read returns the pre-clear value
    p_stat_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == SEL_STAT) |=> rdata[OVF_BIT] == $past(irq));
endmodule

bind slowclk_wdt slowclk_wdt_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .RST_LEN (RST_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .slow_clk (slow_clk),
    .slow_rst (slow_rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .wd_rst   (wd_rst),
    .irq      (irq)
);

// File: tb/slowclk_wdt_bench.sv
module slowclk_wdt_bench;
    localparam int CYC  = 8;
    localparam int UNIT = 64;
    localparam int LAT  = 3;

    logic        clk = 1'b0, slow_clk = 1'b0;
    logic        rst = 1'b1, slow_rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wd_rst, irq;

    int checks = 0, errors = 0, rises = 0;
    bit prev_rst = 1'b0;

    always #(CYC/2) clk = ~clk;
    initial begin
        #3;
        forever #24 slow_clk = ~slow_clk;
    end

    slowclk_wdt u_slowclk_wdt (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wd_rst(wd_rst), .irq(irq)
    );

    always @(negedge slow_clk) begin
        if (wd_rst && !prev_rst) rises = rises + 1;
        prev_rst = wd_rst;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic slow_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge slow_clk);
    endtask

    function automatic logic [31:0] mword(input bit en, input int t);
        return {15'd0, en, t[15:0]};
    endfunction

    // restart right after a slow edge; count edges to pulse and pulse length
    task automatic timed_restart(input int mid_at, input logic [31:0] mid_word,
                                 output int n, output int h);
        @(posedge slow_clk);
        bus_wr(2'd1, 32'h1);
        n = 0; h = 0;
        while (h == 0 && n < 2000) begin
            @(posedge slow_clk); n++;
            @(negedge slow_clk);
            if (wd_rst) h = 1;
            else if (n == mid_at) bus_wr(2'd0, mid_word);
        end
        while (h > 0 && h < 20) begin
            @(negedge slow_clk);
            if (wd_rst) h++; else break;
        end
    endtask

    initial begin
        #(CYC*200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n, h, r0;
        repeat (12) @(negedge clk);
        rst = 1'b0; slow_rst = 1'b0;
        slow_wait(2);

        // R1 reset state
        bus_rd(2'd0, d); chk(d == 0, "R1 mode", d, 0);
        bus_rd(2'd2, d); chk(d == 0, "R1 status", d, 0);
        chk(!irq && !wd_rst, "R1 outputs", {irq, wd_rst}, 0);

        // R9 restart with whole mode zero is ignored
        timed_restart(-1, 0, n, h);
        chk(h == 0 && rises == 0 && !irq, "R9 restart while disabled", rises, 0);

        // R2, R3, R6, R8 sweep of timeout with reset-enable set
        for (int t = 1; t <= 3; t++) begin
            bus_wr(2'd0, mword(1'b1, t) | 32'hFFFE_0000);
            bus_rd(2'd0, d); chk(d == mword(1'b1, t), "R2 mode readback", d, mword(1'b1, t));
            bus_rd(2'd1, d); chk(d == 0, "R2 control reads zero", d, 0);
            timed_restart(-1, 0, n, h);
            chk(n == UNIT*t + LAT, "R3 expiry edge", n, UNIT*t + LAT);
            chk(h == 4, "R6 pulse length", h, 4);
            repeat (6) @(negedge clk);
            chk(irq == 1'b1, "R8 irq set", irq, 1);
            bus_rd(2'd2, d); chk(d == 32'h1, "R8 status read value", d, 1);
            chk(irq == 1'b0, "R8 irq cleared", irq, 0);
            bus_rd(2'd2, d); chk(d == 0, "R8 status after clear", d, 0);
        end

        // R7 reset-enable clear: status only
        bus_wr(2'd0, mword(1'b0, 2));
        r0 = rises;
        @(posedge slow_clk);
        bus_wr(2'd1, 32'h1);
        slow_wait(UNIT*2);
        chk(irq == 1'b0, "R7 no status before expiry", irq, 0);
        slow_wait(10);
        chk(irq == 1'b1, "R7 status on expiry", irq, 1);
        chk(rises == r0, "R7 no reset pulse", rises - r0, 0);
        bus_rd(2'd2, d);

        // R4 restart mid-count gives a fresh full timeout
        bus_wr(2'd0, mword(1'b1, 2));
        r0 = rises;
        @(posedge slow_clk);
        bus_wr(2'd1, 32'h1);
        slow_wait(100);
        timed_restart(-1, 0, n, h);
        chk(n == UNIT*2 + LAT, "R4 timeout from later restart", n, UNIT*2 + LAT);
        chk(rises == r0 + 1, "R4 single pulse", rises - r0, 1);
        repeat (6) @(negedge clk);
        bus_rd(2'd2, d);

        // R5 mode write mid-count does not restart; next restart uses it
        bus_wr(2'd0, mword(1'b1, 3));
        timed_restart(30, mword(1'b1, 1), n, h);
        chk(n == UNIT*3 + LAT, "R5 old timeout kept", n, UNIT*3 + LAT);
        timed_restart(-1, 0, n, h);
        chk(n == UNIT*1 + LAT, "R5 new timeout at restart", n, UNIT + LAT);
        repeat (6) @(negedge clk);
        bus_rd(2'd2, d);

        // R9 writing zero stops a running count
        bus_wr(2'd0, mword(1'b1, 2));
        r0 = rises;
        @(posedge slow_clk);
        bus_wr(2'd1, 32'h1);
        slow_wait(20);
        bus_wr(2'd0, 32'h0);
        slow_wait(300);
        chk(rises == r0 && !irq, "R9 disable stops count", rises - r0, 0);

        // R10 zero timeout field with enable set stays idle
        bus_wr(2'd0, mword(1'b1, 0));
        @(posedge slow_clk);
        bus_wr(2'd1, 32'h1);
        slow_wait(250);
        chk(rises == r0 && !irq, "R10 zero timeout idle", rises - r0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule